// File: doc/BRIEF.md
# Spare Area Sectioned Copy Engine

This block moves the out-of-band (spare) bytes of a flash page between two on-chip memories. One is a packed linear buffer in which the spare bytes of the whole page sit back to back. The other is a sectioned spare RAM in which every 512-byte sub-page of the page owns a slot of fixed stride. A controller hands the engine the page size, the total spare size and the slot stride, then pulses start. The direction input picks gather (sectioned RAM to linear buffer) or scatter (linear buffer to sectioned RAM).

The spare bytes are split evenly over the sections. Each section except the last gets the spare size divided by the section count, rounded down to an even number. The last section takes whatever remains. Each side's memory is reached through a plain synchronous read port with one cycle of latency and a write port. The engine streams one byte per clock and pulses done when the final write has been presented.

Top module: `spare_sect_copier`

## Requirements
- R1: The section count is the page size shifted right by 9 (integer division by 512). A page smaller than 512 bytes is treated as one section.
- R2: Every section except the last copies floor(oob / sections) with bit 0 cleared (rounded down to even).
- R3: The last section copies oob minus (sections - 1) times the per-section length.
- R4: Section i begins at linear offset i*per_len and at sectioned offset i*stride. Bytes within a section are copied at ascending consecutive offsets, and sections are copied in ascending order.
- R5: With dir_scatter = 0 (gather) the engine reads only the sectioned port and writes only the linear port. With dir_scatter = 1 (scatter) it reads only the linear port and writes only the sectioned port.
- R6: With a single section, the full spare size is copied between offset 0 on both sides.
- R7: When the per-section length rounds to zero, all bytes belong to the last section, which starts at linear offset 0 and sectioned offset (sections - 1)*stride.
- R8: Each byte's write is presented one cycle after its read. Done pulses high for exactly one cycle, oob+1 clock edges after the edge that captured start; with oob = 0 it still pulses after one edge and nothing is written.
- R9: Busy rises the cycle after an accepted start. A start, or a change of any configuration input, while busy has no effect on the copy in progress.
- R10: No location outside the destination byte set is written, and the source memory is never written.
- R11: While reset is high and after it, busy, done and all read and write enables are low until a start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Launch pulse, accepted when idle |
| dir_scatter | input | 1 | 1: linear to sectioned, 0: sectioned to linear |
| page_bytes | input | PG_W | Main page size in bytes |
| oob_bytes | input | OOB_W | Total spare bytes of the page |
| slot_stride | input | STR_W | Slot pitch of the sectioned RAM in bytes |
| busy | output | 1 | Copy in progress |
| done | output | 1 | One-cycle completion pulse |
| lin_rd_en | output | 1 | Linear buffer read enable |
| lin_rd_addr | output | LIN_AW | Linear buffer read address |
| lin_rd_data | input | DW | Linear buffer read data, one cycle after enable |
| lin_wr_en | output | 1 | Linear buffer write enable |
| lin_wr_addr | output | LIN_AW | Linear buffer write address |
| lin_wr_data | output | DW | Linear buffer write data |
| sec_rd_en | output | 1 | Sectioned RAM read enable |
| sec_rd_addr | output | SEC_AW | Sectioned RAM read address |
| sec_rd_data | input | DW | Sectioned RAM read data, one cycle after enable |
| sec_wr_en | output | 1 | Sectioned RAM write enable |
| sec_wr_addr | output | SEC_AW | Sectioned RAM write address |
| sec_wr_data | output | DW | Sectioned RAM write data |

## Verification
The hardest situation to reach is a page whose spare size is so small that the per-section length rounds to zero. The engine must then skip every empty section and land the bytes in the last slot. A second awkward case is a non-power-of-two section count, which makes the last section longer than the others. The sweep reaches both by crossing page sizes of 256, 512, 1024, 1536 and 2048 bytes with spare sizes of 0, 1, 7, 16, 40 and 64 bytes, under both strides and both directions, and compares every byte of both memories with an arithmetic model. One configuration also raises start with altered inputs in mid-copy, to show the running copy is unaffected.

// File: rtl/spx_pkg.sv
package spx_pkg;

    localparam int CW = 16;
    typedef logic [CW-1:0] cnt_t;
    localparam cnt_t CNT_ONE = cnt_t'(1);

    typedef enum logic [1:0] {
        WK_IDLE  = 2'd0,
        WK_RUN   = 2'd1,
        WK_DRAIN = 2'd2
    } wk_state_e;

    typedef struct packed {
        cnt_t nsec;       // number of sub-page sections (>= 1)
        cnt_t per_len;    // bytes in each non-final section (even)
        cnt_t last_len;   // bytes in the final section
        cnt_t first_sec;  // first section that holds any byte
        cnt_t total;      // total spare bytes to move
    } plan_t;

    function automatic plan_t spx_make_plan(cnt_t page, cnt_t oob, int unsigned shift);
        plan_t p;
        cnt_t  q;
        p.nsec = page >> shift;
        if (p.nsec == '0)
            p.nsec = CNT_ONE;
        q          = oob / p.nsec;
        p.per_len  = q & ~CNT_ONE;
        p.last_len = oob - (p.nsec - CNT_ONE) * p.per_len;
        p.first_sec = (p.per_len == '0) ? (p.nsec - CNT_ONE) : '0;
        p.total    = oob;
        return p;
    endfunction

endpackage

// File: rtl/spx_planner.sv
module spx_planner
    import spx_pkg::*;
#(
    parameter int PG_W      = 13,
    parameter int OOB_W     = 9,
    parameter int SUB_SHIFT = 9
) (
    input  logic [PG_W-1:0]  page_bytes_i,
    input  logic [OOB_W-1:0] oob_bytes_i,
    output plan_t            plan_o
);

    always_comb begin
        plan_o = spx_make_plan(cnt_t'(page_bytes_i), cnt_t'(oob_bytes_i), SUB_SHIFT);
    end

endmodule

// File: rtl/spx_walker.sv
module spx_walker
    import spx_pkg::*;
#(
    parameter int LIN_AW = 9,
    parameter int SEC_AW = 10
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start_i,
    input  logic              scatter_i,
    input  plan_t             plan_i,
    input  cnt_t              stride_i,
    output wk_state_e         state_o,
    output logic              valid_o,
    output logic              scatter_o,
    output logic [LIN_AW-1:0] lin_off_o,
    output logic [SEC_AW-1:0] sec_off_o
);

    wk_state_e state_q;
    logic      dir_q;
    cnt_t      nsec_q, per_q, last_q, stride_q;
    cnt_t      sec_idx_q, pos_q, lin_base_q, sec_base_q, left_q;
    cnt_t      cur_len;
    logic      sec_end, final_beat;

    always_comb begin
        cur_len    = (sec_idx_q == nsec_q - CNT_ONE) ? last_q : per_q;
        sec_end    = (pos_q == cur_len - CNT_ONE);
        final_beat = (left_q == CNT_ONE);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q    <= WK_IDLE;
            dir_q      <= 1'b0;
            nsec_q     <= '0;
            per_q      <= '0;
            last_q     <= '0;
            stride_q   <= '0;
            sec_idx_q  <= '0;
            pos_q      <= '0;
            lin_base_q <= '0;
            sec_base_q <= '0;
            left_q     <= '0;
        end else begin
            unique case (state_q)
                WK_IDLE: begin
                    if (start_i) begin
                        dir_q      <= scatter_i;
                        nsec_q     <= plan_i.nsec;
                        per_q      <= plan_i.per_len;
                        last_q     <= plan_i.last_len;
                        stride_q   <= stride_i;
                        sec_idx_q  <= plan_i.first_sec;
                        pos_q      <= '0;
                        lin_base_q <= '0;
                        sec_base_q <= plan_i.first_sec * stride_i;
                        left_q     <= plan_i.total;
                        state_q    <= (plan_i.total == '0) ? WK_DRAIN : WK_RUN;
                    end
                end
                WK_RUN: begin
                    left_q <= left_q - CNT_ONE;
                    if (final_beat) begin
                        state_q <= WK_DRAIN;
                    end else if (sec_end) begin
                        sec_idx_q  <= sec_idx_q + CNT_ONE;
                        pos_q      <= '0;
                        lin_base_q <= lin_base_q + per_q;
                        sec_base_q <= sec_base_q + stride_q;
                    end else begin
                        pos_q <= pos_q + CNT_ONE;
                    end
                end
                WK_DRAIN: state_q <= WK_IDLE;
                default:  state_q <= WK_IDLE;
            endcase
        end
    end

    assign state_o   = state_q;
    assign valid_o   = (state_q == WK_RUN);
    assign scatter_o = dir_q;
    assign lin_off_o = LIN_AW'(lin_base_q + pos_q);
    assign sec_off_o = SEC_AW'(sec_base_q + pos_q);

endmodule

// File: rtl/spx_router.sv
module spx_router
    import spx_pkg::*;
#(
    parameter int LIN_AW = 9,
    parameter int SEC_AW = 10,
    parameter int DW     = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  wk_state_e         state_i,
    input  logic              valid_i,
    input  logic              scatter_i,
    input  logic [LIN_AW-1:0] lin_off_i,
    input  logic [SEC_AW-1:0] sec_off_i,
    input  logic [DW-1:0]     lin_rd_data_i,
    input  logic [DW-1:0]     sec_rd_data_i,
    output logic              lin_rd_en_o,
    output logic [LIN_AW-1:0] lin_rd_addr_o,
    output logic              sec_rd_en_o,
    output logic [SEC_AW-1:0] sec_rd_addr_o,
    output logic              lin_wr_en_o,
    output logic [LIN_AW-1:0] lin_wr_addr_o,
    output logic [DW-1:0]     lin_wr_data_o,
    output logic              sec_wr_en_o,
    output logic [SEC_AW-1:0] sec_wr_addr_o,
    output logic [DW-1:0]     sec_wr_data_o,
    output logic              done_o
);

    logic              wv_q, wdir_q, done_q;
    logic [LIN_AW-1:0] wlin_q;
    logic [SEC_AW-1:0] wsec_q;

    // read side: only the source memory is enabled
    assign lin_rd_en_o   = valid_i & scatter_i;
    assign sec_rd_en_o   = valid_i & ~scatter_i;
    assign lin_rd_addr_o = lin_off_i;
    assign sec_rd_addr_o = sec_off_i;

    // destination address waits one cycle for the read latency
    always_ff @(posedge clk) begin
        if (rst) begin
            wv_q   <= 1'b0;
            wdir_q <= 1'b0;
            wlin_q <= '0;
            wsec_q <= '0;
            done_q <= 1'b0;
        end else begin
            wv_q   <= valid_i;
            wdir_q <= scatter_i;
            wlin_q <= lin_off_i;
            wsec_q <= sec_off_i;
            done_q <= (state_i == WK_DRAIN);
        end
    end

    assign lin_wr_en_o   = wv_q & ~wdir_q;
    assign lin_wr_addr_o = wlin_q;
    assign lin_wr_data_o = sec_rd_data_i;
    assign sec_wr_en_o   = wv_q & wdir_q;
    assign sec_wr_addr_o = wsec_q;
    assign sec_wr_data_o = lin_rd_data_i;
    assign done_o        = done_q;

endmodule

// File: rtl/spare_sect_copier.sv
module spare_sect_copier
    import spx_pkg::*;
#(
    parameter int PG_W      = 13,
    parameter int OOB_W     = 9,
    parameter int STR_W     = 8,
    parameter int LIN_AW    = 9,
    parameter int SEC_AW    = 10,
    parameter int DW        = 8,
    parameter int SUB_SHIFT = 9
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic              dir_scatter,
    input  logic [PG_W-1:0]   page_bytes,
    input  logic [OOB_W-1:0]  oob_bytes,
    input  logic [STR_W-1:0]  slot_stride,
    output logic              busy,
    output logic              done,
    output logic              lin_rd_en,
    output logic [LIN_AW-1:0] lin_rd_addr,
    input  logic [DW-1:0]     lin_rd_data,
    output logic              lin_wr_en,
    output logic [LIN_AW-1:0] lin_wr_addr,
    output logic [DW-1:0]     lin_wr_data,
    output logic              sec_rd_en,
    output logic [SEC_AW-1:0] sec_rd_addr,
    input  logic [DW-1:0]     sec_rd_data,
    output logic              sec_wr_en,
    output logic [SEC_AW-1:0] sec_wr_addr,
    output logic [DW-1:0]     sec_wr_data
);

    plan_t             plan;
    wk_state_e         wk_state;
    logic              beat_valid, beat_scatter;
    logic [LIN_AW-1:0] beat_lin;
    logic [SEC_AW-1:0] beat_sec;

    spx_planner #(
        .PG_W(PG_W), .OOB_W(OOB_W), .SUB_SHIFT(SUB_SHIFT)
    ) planner_i (
        .page_bytes_i(page_bytes),
        .oob_bytes_i (oob_bytes),
        .plan_o      (plan)
    );

    spx_walker #(
        .LIN_AW(LIN_AW), .SEC_AW(SEC_AW)
    ) walker_i (
        .clk      (clk),
        .rst      (rst),
        .start_i  (start),
        .scatter_i(dir_scatter),
        .plan_i   (plan),
        .stride_i (cnt_t'(slot_stride)),
        .state_o  (wk_state),
        .valid_o  (beat_valid),
        .scatter_o(beat_scatter),
        .lin_off_o(beat_lin),
        .sec_off_o(beat_sec)
    );

    spx_router #(
        .LIN_AW(LIN_AW), .SEC_AW(SEC_AW), .DW(DW)
    ) router_i (
        .clk          (clk),
        .rst          (rst),
        .state_i      (wk_state),
        .valid_i      (beat_valid),
        .scatter_i    (beat_scatter),
        .lin_off_i    (beat_lin),
        .sec_off_i    (beat_sec),
        .lin_rd_data_i(lin_rd_data),
        .sec_rd_data_i(sec_rd_data),
        .lin_rd_en_o  (lin_rd_en),
        .lin_rd_addr_o(lin_rd_addr),
        .sec_rd_en_o  (sec_rd_en),
        .sec_rd_addr_o(sec_rd_addr),
        .lin_wr_en_o  (lin_wr_en),
        .lin_wr_addr_o(lin_wr_addr),
        .lin_wr_data_o(lin_wr_data),
        .sec_wr_en_o  (sec_wr_en),
        .sec_wr_addr_o(sec_wr_addr),
        .sec_wr_data_o(sec_wr_data),
        .done_o       (done)
    );

    assign busy = (wk_state != WK_IDLE);

endmodule

// File: rtl/spx_chk.sv
module spx_chk (
    input logic clk,
    input logic rst,
    input logic start,
    input logic busy,
    input logic done,
    input logic lin_rd_en,
    input logic lin_wr_en,
    input logic sec_rd_en,
    input logic sec_wr_en
);

    // R11
    reset_quiet_chk: assert property (@(posedge clk)
        rst |=> (!busy && !done && !lin_wr_en && !sec_wr_en && !lin_rd_en && !sec_rd_en));

    // R5
    one_read_side_chk: assert property (@(posedge clk) disable iff (rst)
        !(lin_rd_en && sec_rd_en));

    // R8
    scatter_pipe_chk: assert property (@(posedge clk) disable iff (rst)
        lin_rd_en |=> (sec_wr_en && !lin_wr_en));

    // R8
    gather_pipe_chk: assert property (@(posedge clk) disable iff (rst)
        sec_rd_en |=> (lin_wr_en && !sec_wr_en));

    // R8
    done_single_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R8
    done_after_busy_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> ($past(busy) && !busy));

    // R10
    write_in_busy_chk: assert property (@(posedge clk) disable iff (rst)
        (lin_wr_en || sec_wr_en) |-> busy);

    // R9
    launch_chk: assert property (@(posedge clk) disable iff (rst)
        (start && !busy) |=> busy);

endmodule

bind spare_sect_copier spx_chk chk_i (
    .clk      (clk),
    .rst      (rst),
    .start    (start),
    .busy     (busy),
    .done     (done),
    .lin_rd_en(lin_rd_en),
    .lin_wr_en(lin_wr_en),
    .sec_rd_en(sec_rd_en),
    .sec_wr_en(sec_wr_en)
);

// File: tb/spare_sect_copier_tb_top.sv
`timescale 1ns/1ps
module spare_sect_copier_tb_top;

    localparam int PG_W   = 13;
    localparam int OOB_W  = 9;
    localparam int STR_W  = 8;
    localparam int LIN_AW = 9;
    localparam int SEC_AW = 10;
    localparam int DW     = 8;
    localparam int LIN_N  = 1 << LIN_AW;
    localparam int SEC_N  = 1 << SEC_AW;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              start = 1'b0;
    logic              dir_scatter = 1'b0;
    logic [PG_W-1:0]   page_bytes = '0;
    logic [OOB_W-1:0]  oob_bytes = '0;
    logic [STR_W-1:0]  slot_stride = '0;
    logic              busy, done;
    logic              lin_rd_en, lin_wr_en, sec_rd_en, sec_wr_en;
    logic [LIN_AW-1:0] lin_rd_addr, lin_wr_addr;
    logic [SEC_AW-1:0] sec_rd_addr, sec_wr_addr;
    logic [DW-1:0]     lin_rd_data = '0, sec_rd_data = '0, lin_wr_data, sec_wr_data;

    logic [DW-1:0] lin_mem [LIN_N];
    logic [DW-1:0] sec_mem [SEC_N];
    logic [DW-1:0] exp_lin [LIN_N];
    logic [DW-1:0] exp_sec [SEC_N];

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    spare_sect_copier dut_i (
        .clk(clk), .rst(rst), .start(start), .dir_scatter(dir_scatter),
        .page_bytes(page_bytes), .oob_bytes(oob_bytes), .slot_stride(slot_stride),
        .busy(busy), .done(done),
        .lin_rd_en(lin_rd_en), .lin_rd_addr(lin_rd_addr), .lin_rd_data(lin_rd_data),
        .lin_wr_en(lin_wr_en), .lin_wr_addr(lin_wr_addr), .lin_wr_data(lin_wr_data),
        .sec_rd_en(sec_rd_en), .sec_rd_addr(sec_rd_addr), .sec_rd_data(sec_rd_data),
        .sec_wr_en(sec_wr_en), .sec_wr_addr(sec_wr_addr), .sec_wr_data(sec_wr_data)
    );

    // synchronous memories with one cycle read latency
    always @(posedge clk) begin
        if (lin_rd_en) lin_rd_data <= lin_mem[lin_rd_addr];
        if (sec_rd_en) sec_rd_data <= sec_mem[sec_rd_addr];
        if (lin_wr_en) lin_mem[lin_wr_addr] <= lin_wr_data;
        if (sec_wr_en) sec_mem[sec_wr_addr] <= sec_wr_data;
    end

    task automatic check(input string tag, input string what, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    task automatic compare_mems(input string lin_tag, input string sec_tag);
        int bad_l = 0, bad_s = 0, fa_l = -1, fa_s = -1;
        for (int a = 0; a < LIN_N; a++)
            if (lin_mem[a] !== exp_lin[a]) begin bad_l++; if (fa_l < 0) fa_l = a; end
        for (int a = 0; a < SEC_N; a++)
            if (sec_mem[a] !== exp_sec[a]) begin bad_s++; if (fa_s < 0) fa_s = a; end
        check(lin_tag, $sformatf("linear mismatches (first at %0d)", fa_l), bad_l, 0);
        check(sec_tag, $sformatf("sectioned mismatches (first at %0d)", fa_s), bad_s, 0);
    endtask

    task automatic run_case(input bit scat, input int page, input int oob,
                            input int stride, input int seed, input bit poke);
        int n, per, len, cnt;
        string tag;
        // fill both memories and build expected images
        @(negedge clk);
        for (int a = 0; a < LIN_N; a++) begin
            lin_mem[a] = DW'(a ^ 8'h5A ^ seed);
            exp_lin[a] = lin_mem[a];
        end
        for (int a = 0; a < SEC_N; a++) begin
            sec_mem[a] = DW'(a * 7 + seed * 3 + 1);
            exp_sec[a] = sec_mem[a];
        end
        n   = page / 512;
        if (n == 0) n = 1;
        per = ((oob / n) / 2) * 2;
        for (int i = 0; i < n; i++) begin
            len = (i == n - 1) ? (oob - (n - 1) * per) : per;
            for (int k = 0; k < len; k++) begin
                if (scat) exp_sec[i * stride + k] = lin_mem[i * per + k];
                else      exp_lin[i * per + k]    = sec_mem[i * stride + k];
            end
        end
        if (oob == 0)        tag = "R8";
        else if (n == 1)     tag = (page < 512) ? "R1 R6" : "R6";
        else if (per == 0)   tag = "R7";
        else                 tag = "R1 R2 R3 R4";
        tag = {"R5 ", tag};

        dir_scatter = scat;
        page_bytes  = PG_W'(page);
        oob_bytes   = OOB_W'(oob);
        slot_stride = STR_W'(stride);
        start       = 1'b1;
        @(posedge clk);
        @(negedge clk);
        start = 1'b0;
        check("R9", "busy after start", busy, 1);
        cnt = 0;
        do begin
            @(posedge clk);
            cnt++;
            @(negedge clk);
            if (poke && cnt == 2) begin
                start       = 1'b1;
                dir_scatter = ~scat;
                oob_bytes   = OOB_W'(oob / 2 + 3);
                page_bytes  = PG_W'(512);
            end else if (poke && cnt == 3) begin
                start = 1'b0;
            end
        end while (!done && cnt < 2000);
        check("R8", $sformatf("edges to done (oob %0d)", oob), cnt, oob + 1);
        @(posedge clk);
        @(negedge clk);
        check("R8", "done width one cycle", done, 0);
        if (poke) check("R9", "busy after ignored start", busy, 0);
        if (scat) compare_mems(poke ? "R9 R10" : "R10", poke ? "R9" : tag);
        else      compare_mems(poke ? "R9" : tag, poke ? "R9 R10" : "R10");
    endtask

    initial begin
        int pages[5]   = '{256, 512, 1024, 1536, 2048};
        int oobs[6]    = '{0, 1, 7, 16, 40, 64};
        int strides[2] = '{16, 64};
        int seed = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R11 reset state
        check("R11", "busy in reset", busy, 0);
        check("R11", "done in reset", done, 0);
        check("R11", "write enables in reset", int'(lin_wr_en) + int'(sec_wr_en), 0);
        check("R11", "read enables in reset", int'(lin_rd_en) + int'(sec_rd_en), 0);
        rst = 1'b0;
        @(negedge clk);
        check("R11", "busy after reset", busy, 0);
        for (int p = 0; p < 5; p++)
            for (int s = 0; s < 2; s++)
                for (int o = 0; o < 6; o++)
                    for (int d = 0; d < 2; d++) begin
                        seed++;
                        run_case(d[0], pages[p], oobs[o], strides[s], seed, 1'b0);
                    end
        // R9 mid-copy start with altered inputs, both directions
        run_case(1'b1, 2048, 64, 64, 77, 1'b1);
        run_case(1'b0, 1536, 40, 16, 78, 1'b1);
        if (!finished) begin
            finished = 1'b1;
            $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        #(8ns * 150000);
        if (!finished) begin
            finished = 1'b1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end

endmodule